// File: doc/BRIEF.md
# Serial Divider-Setting Receiver

This block accepts divider settings for a frequency synthesizer over a three-wire serial port made of a serial clock, a data line and a load strobe. The three serial lines are sampled by a fast system clock through a synchronizer. Each rising serial-clock edge shifts one data bit into a shift register. A rising edge on the load strobe copies the word into one of two holding registers. The last bit shifted before the load is a steering bit that picks the destination.

The reference register holds a 14-bit reference division count and a modulus-select bit for the dual-modulus prescaler. The main register holds a 7-bit swallow count and an 11-bit programmable count. The load strobe has a second use: while it is high, an enable output turns on the switch that routes the speed-up charge pump during lock acquisition.

A pin that is left open floats high through a pull-up. This is modelled by a flag input that says whether anything drives the load line. When nothing drives it, the line reads as high.

Top module: `synth_serial_prog`

## Requirements
- R1: On each rising edge of the synchronized serial clock, the serial data bit is shifted into the low end of a 19-bit shift register, so bits arrive MSB first.
- R2: When the steering bit (the last bit shifted, shift-register bit 0) is 1 at a rising load edge, the reference register takes shift-register bits [15:2] as the 14-bit reference count and bit [1] as the modulus select (0 selects 64/65, 1 selects 128/129).
- R3: When the steering bit is 0 at a rising load edge, the main register takes shift-register bits [18:8] as the 11-bit programmable count and bits [7:1] as the 7-bit swallow count.
- R4: A load leaves the register it does not select unchanged.
- R5: Registered settings change only at a rising load edge. Serial clock pulses while the load line is low, pulses while it is held high, and the falling load edge all leave them unchanged.
- R6: When `ser_load_driven` is 0, the load line reads as high regardless of `ser_load`. This enables the switch and performs a load on the resulting rising edge.
- R7: `pump_sw_en` is 1 while the effective load level is high and 0 while it is low, after the synchronizer delay.
- R8: Synchronous reset clears all registered settings, the shift register and `pump_sw_en` to 0.
- R9: A reference word followed by extra clocked bits keeps only the final 16 bits. Leading extra bits sent before a 16-bit reference word do not affect the reference register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe level when the line is driven |
| ser_load_driven | input | 1 | 1 when the load line is driven; 0 means open (reads high) |
| ref_count | output | 14 | Reference division count |
| prescale_sel | output | 1 | Prescaler modulus select (0: 64/65, 1: 128/129) |
| swallow_count | output | 7 | Swallow counter setting |
| prog_count | output | 11 | Programmable counter setting |
| pump_sw_en | output | 1 | Enable for the speed-up charge-pump switch |

## Verification
The assertions assume that the serial lines move slowly compared with the system clock. Each level must be held for longer than the synchronizer depth plus one cycle. Data may change only while the serial clock is low, so that clock and data leave the synchronizer in step. The stimulus holds every serial level for four system cycles and changes data only in the low phase of the serial clock. This keeps every edge that the assertions reason about clean and single-cycle.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int unsigned REF_CNT_W_D  = 14;
  localparam int unsigned SWALLOW_W_D  = 7;
  localparam int unsigned PROG_W_D     = 11;
  localparam int unsigned SYNC_DEPTH_D = 2;
  localparam logic        STEER_REF    = 1'b1;
  localparam logic        STEER_MAIN   = 1'b0;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int unsigned SR_W = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [SR_W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (shift_en) sr <= {sr[SR_W-2:0], bit_in};
  end

  // R1: new bit enters at the low end, older bits move up by one place
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sr[0] == $past(bit_in)) && (sr[SR_W-1:1] == $past(sr[SR_W-2:0])));

  // R5: no serial edge, no movement
  assert_shift_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr));
endmodule

// File: rtl/sp_latches.sv
module sp_latches
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_CNT_W = REF_CNT_W_D,
  parameter int unsigned SWALLOW_W = SWALLOW_W_D,
  parameter int unsigned PROG_W    = PROG_W_D,
  parameter int unsigned SR_W      = max_u(REF_CNT_W + 2, SWALLOW_W + PROG_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_stb,
  input  logic [SR_W-1:0]      sr,
  output logic [REF_CNT_W-1:0] ref_count,
  output logic                 prescale_sel,
  output logic [SWALLOW_W-1:0] swallow_count,
  output logic [PROG_W-1:0]    prog_count
);
  localparam int unsigned REF_W  = REF_CNT_W + 2;
  localparam int unsigned MAIN_W = SWALLOW_W + PROG_W + 1;

  logic steer;
  assign steer = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_count    <= '0;
      prescale_sel <= 1'b0;
    end else if (load_stb && steer == STEER_REF) begin
      ref_count    <= sr[REF_W-1:2];
      prescale_sel <= sr[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      swallow_count <= '0;
      prog_count    <= '0;
    end else if (load_stb && steer == STEER_MAIN) begin
      prog_count    <= sr[MAIN_W-1:SWALLOW_W+1];
      swallow_count <= sr[SWALLOW_W:1];
    end
  end

  assert_ref_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (load_stb && sr[0]) |=> (ref_count == $past(sr[REF_W-1:2])) && (prescale_sel == $past(sr[1])));

  assert_main_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !sr[0]) |=> (prog_count == $past(sr[MAIN_W-1:SWALLOW_W+1]))
                           && (swallow_count == $past(sr[SWALLOW_W:1])));

  assert_main_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (load_stb && sr[0]) |=> $stable(prog_count) && $stable(swallow_count));

  assert_ref_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !sr[0]) |=> $stable(ref_count) && $stable(prescale_sel));

  assert_hold_between_loads_R5: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> $stable(ref_count) && $stable(prescale_sel)
               && $stable(prog_count) && $stable(swallow_count));
endmodule

// File: rtl/synth_serial_prog.sv
module synth_serial_prog
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_CNT_W  = REF_CNT_W_D,
  parameter int unsigned SWALLOW_W  = SWALLOW_W_D,
  parameter int unsigned PROG_W     = PROG_W_D,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_D
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_clk,
  input  logic                 ser_data,
  input  logic                 ser_load,
  input  logic                 ser_load_driven,
  output logic [REF_CNT_W-1:0] ref_count,
  output logic                 prescale_sel,
  output logic [SWALLOW_W-1:0] swallow_count,
  output logic [PROG_W-1:0]    prog_count,
  output logic                 pump_sw_en
);
  localparam int unsigned SR_W = max_u(REF_CNT_W + 2, SWALLOW_W + PROG_W + 1);

  logic       load_level;
  logic [2:0] raw_lines;
  logic [2:0] synced;
  logic       sclk_s, sdata_s, load_s;
  logic       sclk_q;
  logic       sclk_rise, load_rise;
  logic [SR_W-1:0] sr;

  // open load pin reads as high
  assign load_level = ser_load | ~ser_load_driven;
  assign raw_lines  = {load_level, ser_data, ser_clk};

  sp_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .async_in(raw_lines), .sync_out(synced)
  );

  assign sclk_s  = synced[0];
  assign sdata_s = synced[1];
  assign load_s  = synced[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q     <= 1'b0;
      pump_sw_en <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      pump_sw_en <= load_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign load_rise = load_s & ~pump_sw_en;

  sp_shifter #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(sclk_rise), .bit_in(sdata_s), .sr(sr)
  );

  sp_latches #(
    .REF_CNT_W(REF_CNT_W), .SWALLOW_W(SWALLOW_W), .PROG_W(PROG_W), .SR_W(SR_W)
  ) u_latch (
    .clk(clk), .rst(rst), .load_stb(load_rise), .sr(sr),
    .ref_count(ref_count), .prescale_sel(prescale_sel),
    .swallow_count(swallow_count), .prog_count(prog_count)
  );

  // R8: a reset cycle leaves every output cleared
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (ref_count == '0) && !prescale_sel && (swallow_count == '0)
          && (prog_count == '0) && !pump_sw_en);

  // R7: the switch enable drops only after the synced load level is low
  assert_switch_off_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pump_sw_en) |-> !load_s);
endmodule

// File: tb/test_synth_serial_prog.sv
module test_synth_serial_prog;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, ser_load_driven = 1'b1;
  logic [13:0] ref_count;
  logic        prescale_sel;
  logic [6:0]  swallow_count;
  logic [10:0] prog_count;
  logic        pump_sw_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_serial_prog i_synth_serial_prog (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .ser_load_driven(ser_load_driven),
    .ref_count(ref_count), .prescale_sel(prescale_sel),
    .swallow_count(swallow_count), .prog_count(prog_count), .pump_sw_en(pump_sw_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      ser_clk = 1'b0; ser_data = w[i]; wait_cyc(4);
      ser_clk = 1'b1; wait_cyc(4);
    end
    ser_clk = 1'b0; wait_cyc(4);
  endtask

  task automatic do_load();
    ser_load = 1'b1; wait_cyc(6);
    ser_load = 1'b0; wait_cyc(6);
  endtask

  // expected register state
  logic [13:0] e_ref; logic e_mod; logic [6:0] e_sw; logic [10:0] e_pc;

  task automatic check_all(input string req);
    chk({req, " ref_count"}, 32'(ref_count), 32'(e_ref));
    chk({req, " prescale_sel"}, 32'(prescale_sel), 32'(e_mod));
    chk({req, " swallow_count"}, 32'(swallow_count), 32'(e_sw));
    chk({req, " prog_count"}, 32'(prog_count), 32'(e_pc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    e_ref = '0; e_mod = 0; e_sw = '0; e_pc = '0;
    wait_cyc(5);
    // R8 reset state
    check_all("R8");
    chk("R8 pump_sw_en", 32'(pump_sw_en), 0);
    rst = 1'b0; wait_cyc(4);
    check_all("R8");

    // R2 reference sweep, with R4 check on the main register
    for (int k = 0; k < 64; k++) begin
      logic [13:0] c; logic m;
      c = 14'((k * 2731 + 17) % 16384);
      if (k == 0) c = 14'd0;
      if (k == 1) c = 14'h3FFF;
      m = k[0];
      send_bits({16'd0, c, m, 1'b1}, 16);
      chk("R5 pre-load ref", 32'(ref_count), 32'(e_ref));
      ser_load = 1'b1; wait_cyc(6);
      chk("R7 switch on", 32'(pump_sw_en), 1);
      e_ref = c; e_mod = m;
      check_all("R2/R4");
      ser_load = 1'b0; wait_cyc(6);
      chk("R7 switch off", 32'(pump_sw_en), 0);
    end

    // R3 main sweep over every swallow value, with R4 on the reference register
    for (int s = 0; s < 128; s++) begin
      logic [10:0] p;
      p = 11'((s * 37 + 5) % 2048);
      if (s == 127) p = 11'h7FF;
      send_bits({13'd0, p, 7'(s), 1'b0}, 19);
      do_load();
      e_sw = 7'(s); e_pc = p;
      check_all("R3/R4");
    end

    // R5: shifting while load held high, then the falling edge, changes nothing
    send_bits({16'd0, 14'h1234, 1'b1, 1'b1}, 16);
    ser_load = 1'b1; wait_cyc(6);
    e_ref = 14'h1234; e_mod = 1'b1;
    check_all("R5 load");
    send_bits({13'd0, 11'h555, 7'h2A, 1'b0}, 19);
    check_all("R5 held high");
    ser_load = 1'b0; wait_cyc(6);
    check_all("R5 falling edge");

    // R9: leading extra bits before a reference word are discarded
    send_bits({13'd0, 3'b111, 14'h0F0F, 1'b0, 1'b1}, 19);
    do_load();
    e_ref = 14'h0F0F; e_mod = 1'b0;
    check_all("R9 leading");
    // R9: extra bits after a reference word push it up; a main word of 19 bits decides
    send_bits({13'd0, 11'h3C3, 7'h11, 1'b0}, 19);
    send_bits(32'h0, 0);
    do_load();
    e_pc = 11'h3C3; e_sw = 7'h11;
    check_all("R9 last bits");

    // R6: load line left open reads high
    send_bits({16'd0, 14'h2AAA, 1'b1, 1'b1}, 16);
    ser_load = 1'b0; ser_load_driven = 1'b0; wait_cyc(6);
    chk("R6 switch on when open", 32'(pump_sw_en), 1);
    e_ref = 14'h2AAA; e_mod = 1'b1;
    check_all("R6");
    ser_load_driven = 1'b1; wait_cyc(6);
    chk("R7 switch off when driven low", 32'(pump_sw_en), 0);

    // R8 reset after activity
    rst = 1'b1; wait_cyc(3);
    e_ref = '0; e_mod = 0; e_sw = '0; e_pc = '0;
    check_all("R8 second reset");
    chk("R8 pump_sw_en", 32'(pump_sw_en), 0);
    rst = 1'b0; wait_cyc(4);
    // R1: after reset, shift register cleared: a lone steering 0 yields a zero main word
    send_bits(32'h0, 1);
    do_load();
    check_all("R1/R8 cleared shifter");
    // R1: MSB-first order, single-bit markers
    send_bits({13'd0, 11'h400, 7'h01, 1'b0}, 19);
    do_load();
    e_pc = 11'h400; e_sw = 7'h01;
    check_all("R1 order");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule